// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. A receive clock enable `rx_tick` paces it. The enable runs at one, sixteen or sixty-four times the bit rate. On each tick the block samples `rx_line`.

After reset the receiver stays disarmed until it sees the line high once. From then on, a falling edge starts a frame. In the oversampled modes a start bit that does not hold to its centre is discarded as noise. The block then gathers 5 to 8 data bits, least significant first, and an optional parity bit. It checks a single stop bit.

The finished character goes into a data register together with a ready flag. Sticky parity, overrun and framing flags describe the character. A separate flag reports a break, meaning a line held low for two whole frames. The surrounding logic programs the format through static configuration inputs. It takes characters with a read strobe and clears the error flags with a clear pulse.

Top module: `osr_serial_rx`

## Requirements
- R1: After reset, no frame is started until `rx_line` has been seen high on at least one tick. A line held low from reset produces no character.
- R2: A frame begins on a tick where the line is low and was high on the previous tick. In 16x and 64x modes the line is sampled again 8 or 32 ticks later. If it is high then, the frame is dropped, no character is delivered and the receiver waits for the next falling edge.
- R3: `cfg_factor` selects the sampling rate: 2'b10 gives 16 ticks per bit, 2'b11 gives 64, and any other code gives 1. In 1x mode the bits are sampled on the ticks that follow the start edge. In the oversampled modes each later bit is sampled one full bit period after the previous sample point.
- R4: `cfg_len` selects the character length: 2'b00 is 5 bits, 2'b01 is 6, 2'b10 is 7 and 2'b11 is 8. The first bit received lands in `rx_data[0]`, and the data bits above the length read as zero.
- R5: With `cfg_par_en` high, one parity bit follows the data. It is checked for even parity when `cfg_par_even` is 1 and for odd parity when it is 0. A mismatch sets `err_parity`. The parity bit never appears in `rx_data`.
- R6: Exactly one stop bit is sampled. If it is low, `err_frame` is set, and the character is still delivered.
- R7: `rx_ready` rises when a character is loaded and falls after `data_rd`. While `rx_enable` is low it is forced to zero.
- R8: If a character is loaded while `rx_ready` is still set, or in the same cycle as `data_rd`, the new character replaces the old one and `err_overrun` is set.
- R9: The three error flags stay set until `err_clear`, and a set flag does not stop later characters from being received.
- R10: `brk_flag` sets once the line has been low for 2 × (2 + length + parity) bit periods of ticks in a row. It clears on the first tick that sees the line high.
- R11: Reset clears `rx_data`, `rx_ready`, all error flags and `brk_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_tick | input | 1 | Receive clock enable, one pulse per sample slot |
| rx_line | input | 1 | Serial input line, idle high |
| cfg_factor | input | 2 | Sampling rate select |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| rx_enable | input | 1 | Receiver enable; low holds ready cleared |
| err_clear | input | 1 | Pulse that clears the error flags |
| data_rd | input | 1 | Character read strobe |
| rx_data | output | MAX_LEN | Last received character |
| rx_ready | output | 1 | Character waiting to be read |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| err_frame | output | 1 | Sticky framing error |
| brk_flag | output | 1 | Break condition on the line |

## Verification
Some properties are checked on every cycle:
- the receiver stays idle until it is armed;
- a disabled or just-read ready flag stays low;
- overrun is flagged on an unread load;
- errors stay sticky;
- break clears on a high tick;
- upper data bits are zero for short characters;
- a frame without parity leaves the parity flag alone.

Other behaviours need the directed scenarios, because they depend on whole frames of line activity:
- the sample-point timing at each rate;
- bit order and parity sense;
- rejection of a noise start;
- framing errors;
- overrun from a read that lands in the loading cycle;
- the break threshold.

// File: rtl/osr_rx_pkg.sv
package osr_rx_pkg;
   typedef enum logic [2:0] {
      RX_IDLE  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4
   } rx_phase_e;

   localparam logic [1:0] OVS_MID  = 2'b10;
   localparam logic [1:0] OVS_FAST = 2'b11;
endpackage

// File: rtl/osr_rx_arm.sv
module osr_rx_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_tick,
   input  logic rx_line,
   output logic armed,
   output logic fall_seen
);
   logic line_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed  <= 1'b0;
         line_q <= 1'b1;
      end else if (rx_tick) begin
         line_q <= rx_line;
         if (rx_line) armed <= 1'b1;
      end
   end

   assign fall_seen = rx_tick && armed && line_q && !rx_line;
endmodule

// File: rtl/osr_rx_timer.sv
module osr_rx_timer #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_tick,
   input  logic [CW-1:0] period,
   input  logic          restart,
   input  logic          running,
   output logic          sample_pt
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] target;
   logic          half_q;

   always_comb begin
      if (half_q && (period > CW'(1))) target = period >> 1;
      else                             target = period;
   end

   assign sample_pt = running && rx_tick && (cnt == target - CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         half_q <= 1'b1;
      end else if (restart) begin
         cnt    <= '0;
         half_q <= 1'b1;
      end else if (running && rx_tick) begin
         if (sample_pt) begin
            cnt    <= '0;
            half_q <= 1'b0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end
endmodule

// File: rtl/osr_rx_frame.sv
module osr_rx_frame
   import osr_rx_pkg::*;
#(
   parameter int MAX_LEN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               sample_pt,
   input  logic               rx_line,
   input  logic [1:0]         len_sel,
   input  logic               par_en,
   input  logic               par_even,
   input  logic               x1_mode,
   output logic               busy,
   output logic               xfer,
   output logic [MAX_LEN-1:0] char_q,
   output logic               par_bad,
   output logic               stop_bad
);
   localparam int IW = $clog2(MAX_LEN);

   rx_phase_e          st;
   logic [IW-1:0]      idx;
   logic [IW-1:0]      last_idx;
   logic               acc;
   logic [MAX_LEN-1:0] sh_nxt;

   assign last_idx = IW'(MAX_LEN - 4) + IW'(len_sel);

   for (genvar i = 0; i < MAX_LEN; i++) begin : g_cap
      assign sh_nxt[i] = (idx == IW'(i)) ? rx_line : char_q[i];
   end

   assign busy     = (st != RX_IDLE);
   assign xfer     = sample_pt && (st == RX_STOP);
   assign stop_bad = xfer && !rx_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         idx     <= '0;
         acc     <= 1'b0;
         char_q  <= '0;
         par_bad <= 1'b0;
      end else if (start) begin
         st      <= x1_mode ? RX_DATA : RX_START;
         idx     <= '0;
         acc     <= 1'b0;
         char_q  <= '0;
         par_bad <= 1'b0;
      end else if (sample_pt) begin
         case (st)
            RX_START: st <= rx_line ? RX_IDLE : RX_DATA;
            RX_DATA: begin
               char_q <= sh_nxt;
               acc    <= acc ^ rx_line;
               if (idx == last_idx) st <= par_en ? RX_PAR : RX_STOP;
               else                 idx <= idx + IW'(1);
            end
            RX_PAR: begin
               par_bad <= acc ^ rx_line ^ !par_even;
               st      <= RX_STOP;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/osr_rx_break.sv
module osr_rx_break #(
   parameter int MAX_LEN    = 8,
   parameter int FAST_RATIO = 64,
   parameter int CW         = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_tick,
   input  logic          rx_line,
   input  logic [1:0]    len_sel,
   input  logic          par_en,
   input  logic [CW-1:0] period,
   output logic          brk
);
   localparam int BW = $clog2(2 * (MAX_LEN + 3) * FAST_RATIO + 1);

   logic [BW-1:0] cnt;
   logic [BW-1:0] limit;

   assign limit = BW'(2) * (BW'(MAX_LEN - 1) + BW'(len_sel) + BW'(par_en)) * BW'(period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         brk <= 1'b0;
      end else if (rx_tick) begin
         if (rx_line) begin
            cnt <= '0;
            brk <= 1'b0;
         end else if (cnt >= limit - BW'(1)) begin
            brk <= 1'b1;
         end else begin
            cnt <= cnt + BW'(1);
         end
      end
   end
endmodule

// File: rtl/osr_serial_rx.sv
module osr_serial_rx
   import osr_rx_pkg::*;
#(
   parameter int MAX_LEN    = 8,
   parameter int MID_RATIO  = 16,
   parameter int FAST_RATIO = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_tick,
   input  logic               rx_line,
   input  logic [1:0]         cfg_factor,
   input  logic [1:0]         cfg_len,
   input  logic               cfg_par_en,
   input  logic               cfg_par_even,
   input  logic               rx_enable,
   input  logic               err_clear,
   input  logic               data_rd,
   output logic [MAX_LEN-1:0] rx_data,
   output logic               rx_ready,
   output logic               err_parity,
   output logic               err_overrun,
   output logic               err_frame,
   output logic               brk_flag
);
   localparam int CW = $clog2(FAST_RATIO) + 1;

   if (MAX_LEN < 4) begin : g_bad_len
      $error("MAX_LEN must be at least 4");
   end
   if (MID_RATIO < 2 || (MID_RATIO % 2) != 0) begin : g_bad_mid
      $error("MID_RATIO must be even and at least 2");
   end
   if (FAST_RATIO <= MID_RATIO || (FAST_RATIO % 2) != 0) begin : g_bad_fast
      $error("FAST_RATIO must be even and above MID_RATIO");
   end

   logic [CW-1:0]      period;
   logic               x1_mode;
   logic               armed;
   logic               fall_seen;
   logic               busy;
   logic               start;
   logic               sample_pt;
   logic               xfer;
   logic               par_bad;
   logic               stop_bad;
   logic [MAX_LEN-1:0] char_q;

   always_comb begin
      case (cfg_factor)
         OVS_MID:  period = CW'(MID_RATIO);
         OVS_FAST: period = CW'(FAST_RATIO);
         default:  period = CW'(1);
      endcase
   end

   assign x1_mode = (period == CW'(1));
   assign start   = fall_seen && !busy;

   osr_rx_arm i_arm (
      .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
      .armed(armed), .fall_seen(fall_seen)
   );

   osr_rx_timer #(.CW(CW)) i_timer (
      .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .period(period),
      .restart(start), .running(busy), .sample_pt(sample_pt)
   );

   osr_rx_frame #(.MAX_LEN(MAX_LEN)) i_frame (
      .clk(clk), .rst_n(rst_n), .start(start), .sample_pt(sample_pt),
      .rx_line(rx_line), .len_sel(cfg_len), .par_en(cfg_par_en),
      .par_even(cfg_par_even), .x1_mode(x1_mode), .busy(busy), .xfer(xfer),
      .char_q(char_q), .par_bad(par_bad), .stop_bad(stop_bad)
   );

   osr_rx_break #(.MAX_LEN(MAX_LEN), .FAST_RATIO(FAST_RATIO), .CW(CW)) i_break (
      .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
      .len_sel(cfg_len), .par_en(cfg_par_en), .period(period), .brk(brk_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_ready    <= 1'b0;
         err_parity  <= 1'b0;
         err_overrun <= 1'b0;
         err_frame   <= 1'b0;
      end else begin
         if (xfer) rx_data <= char_q;
         rx_ready <= rx_enable && (xfer || (rx_ready && !data_rd));

         if (xfer && (rx_ready || data_rd)) err_overrun <= 1'b1;
         else if (err_clear)                err_overrun <= 1'b0;

         if (xfer && par_bad)  err_parity <= 1'b1;
         else if (err_clear)   err_parity <= 1'b0;

         if (stop_bad)         err_frame <= 1'b1;
         else if (err_clear)   err_frame <= 1'b0;
      end
   end
endmodule

// File: rtl/osr_rx_checker.sv
module osr_rx_checker #(
   parameter int MAX_LEN = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rx_tick,
   input logic               rx_line,
   input logic [1:0]         cfg_len,
   input logic               cfg_par_en,
   input logic               rx_enable,
   input logic               err_clear,
   input logic               data_rd,
   input logic [MAX_LEN-1:0] rx_data,
   input logic               rx_ready,
   input logic               err_parity,
   input logic               err_overrun,
   input logic               err_frame,
   input logic               brk_flag,
   input logic               armed,
   input logic               busy,
   input logic               xfer
);
   p_idle_until_armed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !busy);

   p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && cfg_len == 2'b00) |=> (rx_data[MAX_LEN-1:MAX_LEN-3] == 3'b000));

   p_no_parity_no_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !cfg_par_en && !err_parity) |=> !err_parity);

   p_ready_off_when_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_enable |=> !rx_ready);

   p_read_clears_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !xfer) |=> !rx_ready);

   p_overrun_unread_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && rx_ready) |=> err_overrun);

   p_parity_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity && !err_clear) |=> err_parity);

   p_frame_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frame && !err_clear) |=> err_frame);

   p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_overrun && !err_clear) |=> err_overrun);

   p_break_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_tick && rx_line) |=> !brk_flag);
endmodule

bind osr_serial_rx osr_rx_checker #(.MAX_LEN(MAX_LEN)) i_chk (
   .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
   .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .rx_enable(rx_enable),
   .err_clear(err_clear), .data_rd(data_rd), .rx_data(rx_data),
   .rx_ready(rx_ready), .err_parity(err_parity), .err_overrun(err_overrun),
   .err_frame(err_frame), .brk_flag(brk_flag), .armed(armed), .busy(busy),
   .xfer(xfer)
);

// File: tb/test_osr_serial_rx.sv
`timescale 1ns/1ps
module test_osr_serial_rx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_tick = 1'b1;
   logic       rx_line = 1'b0;
   logic [1:0] cfg_factor = 2'b01;
   logic [1:0] cfg_len = 2'b11;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       rx_enable = 1'b1;
   logic       err_clear = 1'b0;
   logic       data_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_ready, err_parity, err_overrun, err_frame, brk_flag;

   int n_cmp = 0;
   int n_bad = 0;
   int per = 1;
   int len = 8;

   always #2.5 clk = ~clk;

   osr_serial_rx i_osr_serial_rx (
      .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_line(rx_line),
      .cfg_factor(cfg_factor), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .rx_enable(rx_enable), .err_clear(err_clear),
      .data_rd(data_rd), .rx_data(rx_data), .rx_ready(rx_ready),
      .err_parity(err_parity), .err_overrun(err_overrun), .err_frame(err_frame),
      .brk_flag(brk_flag)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_bit(input logic b, input int n);
      rx_line = b;
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input logic [1:0] f, input logic [1:0] l, input logic pen, input logic pev);
      cfg_factor = f; cfg_len = l; cfg_par_en = pen; cfg_par_even = pev;
      per = (f == 2'b10) ? 16 : (f == 2'b11) ? 64 : 1;
      len = 5 + int'(l);
      drive_bit(1'b1, 4);
   endtask

   task automatic flush();
      data_rd = 1'b1; err_clear = 1'b1;
      @(negedge clk);
      data_rd = 1'b0; err_clear = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] v, input bit flip_par, input logic stop_v, input bit rd_stop);
      logic [7:0] m;
      logic p;
      m = v & 8'((1 << len) - 1);
      p = (^m) ^ !cfg_par_even ^ flip_par;
      drive_bit(1'b0, per);
      for (int i = 0; i < len; i++) drive_bit(v[i], per);
      if (cfg_par_en) drive_bit(p, per);
      rx_line = stop_v; data_rd = rd_stop;
      @(negedge clk);
      data_rd = 1'b0;
      repeat (per - 1) @(negedge clk);
      drive_bit(1'b1, 3);
   endtask

   task automatic t_reset();
      check("R11", "rx_data", int'(rx_data), 0);
      check("R11", "flags", int'({rx_ready, err_parity, err_overrun, err_frame, brk_flag}), 0);
   endtask

   task automatic t_arm();
      drive_bit(1'b0, 12);
      check("R1", "ready with line low since reset", int'(rx_ready), 0);
      drive_bit(1'b1, 3);
      check("R1", "ready after line high", int'(rx_ready), 0);
      send_frame(8'h3C, 0, 1'b1, 0);
      check("R1", "first char after arming", int'(rx_data), 'h3C);
      flush();
   endtask

   task automatic t_1x_basic();
      set_cfg(2'b01, 2'b11, 1'b0, 1'b0);
      send_frame(8'hA5, 0, 1'b1, 0);
      check("R3", "1x data", int'(rx_data), 'hA5);
      check("R7", "ready set on load", int'(rx_ready), 1);
      check("R6", "no framing error", int'(err_frame), 0);
      flush();
      check("R7", "ready after read", int'(rx_ready), 0);
   endtask

   task automatic t_16x_parity();
      set_cfg(2'b10, 2'b10, 1'b1, 1'b1);
      send_frame(8'h5A, 0, 1'b1, 0);
      check("R5", "16x even good data", int'(rx_data), 'h5A);
      check("R5", "parity ok", int'(err_parity), 0);
      flush();
      send_frame(8'h11, 1, 1'b1, 0);
      check("R5", "bad parity flagged", int'(err_parity), 1);
      check("R5", "data excludes parity", int'(rx_data), 'h11);
      check("R8", "no overrun after read", int'(err_overrun), 0);
      flush();
   endtask

   task automatic t_64x_short();
      set_cfg(2'b11, 2'b00, 1'b1, 1'b0);
      send_frame(8'hF3, 0, 1'b1, 0);
      check("R4", "5-bit char, upper zero", int'(rx_data), 'h13);
      check("R5", "odd parity ok", int'(err_parity), 0);
      check("R3", "64x ready", int'(rx_ready), 1);
      flush();
   endtask

   task automatic t_false_start();
      set_cfg(2'b10, 2'b11, 1'b0, 1'b0);
      drive_bit(1'b0, 4);
      drive_bit(1'b1, 40);
      check("R2", "glitch gives no ready", int'(rx_ready), 0);
      check("R2", "glitch leaves data", int'(rx_data), 'h13);
      send_frame(8'h81, 0, 1'b1, 0);
      check("R2", "next frame received", int'(rx_data), 'h81);
      flush();
   endtask

   task automatic t_frame_err();
      set_cfg(2'b01, 2'b11, 1'b0, 1'b0);
      send_frame(8'h66, 0, 1'b0, 0);
      check("R6", "framing error set", int'(err_frame), 1);
      check("R6", "char still delivered", int'(rx_data), 'h66);
      data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
      send_frame(8'h99, 0, 1'b1, 0);
      check("R9", "reception continues", int'(rx_data), 'h99);
      check("R9", "framing flag sticky", int'(err_frame), 1);
      flush();
      check("R9", "cleared by err_clear", int'(err_frame), 0);
   endtask

   task automatic t_overrun();
      send_frame(8'h11, 0, 1'b1, 0);
      send_frame(8'h22, 0, 1'b1, 0);
      check("R8", "overrun on unread", int'(err_overrun), 1);
      check("R8", "newer char kept", int'(rx_data), 'h22);
      flush();
      send_frame(8'h33, 0, 1'b1, 0);
      send_frame(8'h44, 0, 1'b1, 1);
      check("R8", "overrun on coincident read", int'(err_overrun), 1);
      check("R8", "ready after coincident read", int'(rx_ready), 1);
      check("R8", "coincident data", int'(rx_data), 'h44);
      flush();
   endtask

   task automatic t_enable();
      rx_enable = 1'b0;
      send_frame(8'h55, 0, 1'b1, 0);
      check("R7", "ready held off", int'(rx_ready), 0);
      rx_enable = 1'b1;
      drive_bit(1'b1, 2);
      check("R7", "ready stays off on enable", int'(rx_ready), 0);
      send_frame(8'h56, 0, 1'b1, 0);
      check("R7", "ready after enable", int'(rx_ready), 1);
      flush();
   endtask

   task automatic t_break();
      drive_bit(1'b0, 15);
      check("R10", "no break yet", int'(brk_flag), 0);
      drive_bit(1'b0, 10);
      check("R10", "break after two frames", int'(brk_flag), 1);
      drive_bit(1'b1, 2);
      check("R10", "break cleared by high", int'(brk_flag), 0);
      flush();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_arm();
      t_1x_basic();
      t_16x_parity();
      t_64x_short();
      t_false_start();
      t_frame_err();
      t_overrun();
      t_enable();
      t_break();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule